// File: doc/BRIEF.md
# Loadable BCD Decade Counter

This block holds one decimal digit as a 4-bit BCD value. On each rising clock edge it steps from 0 up to 9 and then wraps back to 0. Two count enables must both be high for it to step. One enable is meant to be driven locally. The other is meant to be passed down a chain of digits. An active-low synchronous load copies a 4-bit data word into the count, and an active-low asynchronous reset clears the count at once.

A carry output goes high when the digit sits at 9 and the chained enable is high. To build a multi-digit counter, feed each digit's carry into the chained enable of the next digit up. Every digit then moves on the same clock edge, in the cycle where all lower digits roll over together. Display decoding and any logic for a modulus other than ten stay outside this block.

Top module: `decade_counter`

## Requirements
- R1: When rst_n is low, count is 0 at once, with no clock edge needed. While rst_n stays low, count stays 0 whatever load_n, load_val and the enables do.
- R2: At a rising edge where rst_n, load_n, en_par and en_trk are all high and count is below 9, count goes up by exactly 1.
- R3: At such an edge with count equal to 9, count becomes 0.
- R4: At a rising edge where rst_n is high and load_n is low, count takes the value of load_val, whatever the two enables are.
- R5: At a rising edge where rst_n and load_n are high and en_par or en_trk is low, count keeps its value.
- R6: carry_out is combinational. It is 1 exactly when count equals 9 (binary 1001) and en_trk is 1, whatever en_par is.
- R7: If a value from 10 to 15 has been loaded, the next enabled increment (as in R2) sets count to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all loads and steps happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low clear; it overrides every other input |
| load_n | input | 1 | Synchronous active-low load strobe |
| load_val | input | 4 | Value copied into count when a load occurs |
| en_par | input | 1 | Local count enable; it does not affect carry_out |
| en_trk | input | 1 | Chained count enable; it also gates carry_out |
| count | output | 4 | Current digit value in BCD |
| carry_out | output | 1 | High while count is 9 and en_trk is high |

## Verification
The bench builds the counter with its default parameters: a 4-bit digit and a modulus of ten. The 4-bit width lets the bench load all six codes above 9 and check that each one steps straight to 0. The modulus of ten puts the wrap at 9 and the carry at code 1001. That lets the bench check the full cycle, the wrap, and carry gating by each enable alone. Reset is checked both when it falls in the middle of a clock period and when it is held low across an active load edge.

// File: rtl/decade_counter_pkg.sv
package decade_counter_pkg;

    // Default geometry of one decimal digit.
    localparam int DIGIT_W_DEF = 4;
    localparam int RADIX_DEF   = 10;

    // The action the counter takes at the next rising edge.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_STEP = 2'd2
    } cnt_action_e;

endpackage

// File: rtl/decade_step.sv
// Successor of a digit value: ends of range and out-of-range codes go to zero.
module decade_step #(
    parameter int DIGIT_W = 4,
    parameter int RADIX   = 10
) (
    input  logic [DIGIT_W-1:0] cur_val,
    output logic [DIGIT_W-1:0] nxt_val
);
    localparam logic [DIGIT_W-1:0] TOP_VAL = DIGIT_W'(RADIX - 1);

    always_comb begin
        if (cur_val >= TOP_VAL) begin
            nxt_val = '0;
        end else begin
            nxt_val = cur_val + DIGIT_W'(1);
        end
    end
endmodule

// File: rtl/decade_carry.sv
// Terminal-count detect, qualified only by the chained enable.
module decade_carry #(
    parameter int DIGIT_W = 4,
    parameter int RADIX   = 10
) (
    input  logic [DIGIT_W-1:0] cur_val,
    input  logic               chain_en,
    output logic               carry
);
    localparam logic [DIGIT_W-1:0] TOP_VAL = DIGIT_W'(RADIX - 1);

    always_comb begin
        carry = chain_en && (cur_val == TOP_VAL);
    end
endmodule

// File: rtl/decade_counter.sv
module decade_counter
    import decade_counter_pkg::*;
#(
    parameter int DIGIT_W = DIGIT_W_DEF,
    parameter int RADIX   = RADIX_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_n,
    input  logic [DIGIT_W-1:0] load_val,
    input  logic               en_par,
    input  logic               en_trk,
    output logic [DIGIT_W-1:0] count,
    output logic               carry_out
);
    localparam logic [DIGIT_W-1:0] TOP_VAL = DIGIT_W'(RADIX - 1);

    typedef struct packed {
        logic [DIGIT_W-1:0] digit;
    } cnt_state_t;

    cnt_state_t         state_d;
    cnt_state_t         state_q;
    cnt_action_e        action;
    logic [DIGIT_W-1:0] step_val;

    decade_step #(
        .DIGIT_W (DIGIT_W),
        .RADIX   (RADIX)
    ) step_i (
        .cur_val (state_q.digit),
        .nxt_val (step_val)
    );

    decade_carry #(
        .DIGIT_W (DIGIT_W),
        .RADIX   (RADIX)
    ) carry_i (
        .cur_val  (state_q.digit),
        .chain_en (en_trk),
        .carry    (carry_out)
    );

    // Load outranks counting; both enables are needed to step.
    always_comb begin
        if (!load_n) begin
            action = ACT_LOAD;
        end else if (en_par && en_trk) begin
            action = ACT_STEP;
        end else begin
            action = ACT_HOLD;
        end

        state_d = state_q;
        case (action)
            ACT_LOAD: state_d.digit = load_val;
            ACT_STEP: state_d.digit = step_val;
            default:  state_d       = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count = state_q.digit;

    // Assertions beside the logic they guard.
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> (count == $past(load_val)));                            // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !(en_par && en_trk)) |=> $stable(count));                // R5

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && en_par && en_trk && (count < TOP_VAL))
            |=> (count == $past(count) + DIGIT_W'(1)));                     // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && en_par && en_trk && (count >= TOP_VAL))
            |=> (count == '0));                                             // R3

    AST_CARRY_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |-> (en_trk && (count == TOP_VAL)));                      // R6

    AST_CARRY_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (en_trk && (count == TOP_VAL)) |-> carry_out);                      // R6

endmodule

// File: tb/decade_counter_tb_top.sv
`timescale 1ns/1ps
module decade_counter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       load_n;
    logic [3:0] load_val;
    logic       en_par;
    logic       en_trk;
    logic [3:0] count;
    logic       carry_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    decade_counter dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_n    (load_n),
        .load_val  (load_val),
        .en_par    (en_par),
        .en_trk    (en_trk),
        .count     (count),
        .carry_out (carry_out)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, actual, expected, $time);
        end
    endtask

    // Advance one rising edge, then settle away from it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load_digit(input logic [3:0] v);
        load_n   = 1'b0;
        load_val = v;
        tick();
        load_n   = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; load_n = 1'b1; load_val = 4'd0; en_par = 1'b0; en_trk = 1'b0;
        #1;
        check("R1 reset value", count, 0);
        check("R6 carry in reset", carry_out, 0);
        // Load attempted while reset is held.
        load_n = 1'b0; load_val = 4'd6; en_par = 1'b1; en_trk = 1'b1;
        tick();
        check("R1 load ignored in reset", count, 0);
        load_n = 1'b1; en_par = 1'b0; en_trk = 1'b0;
        rst_n = 1'b1;
        tick();
        load_digit(4'd7);
        check("R4 preload before reset", count, 7);
        // Reset in the middle of a clock period acts before any edge.
        #0.5;
        rst_n = 1'b0;
        #0.3;
        check("R1 async clear", count, 0);
        tick();
        rst_n = 1'b1;
        tick();
        check("R1 stays clear after release", count, 0);
    endtask

    task automatic t_count();
        int exp_v = count;
        en_par = 1'b1; en_trk = 1'b1;
        for (int i = 0; i < 23; i++) begin
            tick();
            exp_v = (exp_v == 9) ? 0 : exp_v + 1;
            check((exp_v == 0) ? "R3 wrap" : "R2 step", count, exp_v);
        end
        en_par = 1'b0; en_trk = 1'b0;
    endtask

    task automatic t_hold();
        load_digit(4'd4);
        en_par = 1'b0; en_trk = 1'b1;
        tick(); tick();
        check("R5 hold en_par low", count, 4);
        en_par = 1'b1; en_trk = 1'b0;
        tick(); tick();
        check("R5 hold en_trk low", count, 4);
        en_par = 1'b0; en_trk = 1'b0;
        tick();
        check("R5 hold both low", count, 4);
    endtask

    task automatic t_load();
        en_par = 1'b0; en_trk = 1'b0;
        load_digit(4'd2);
        check("R4 load enables low", count, 2);
        en_par = 1'b1; en_trk = 1'b1;
        load_digit(4'd5);
        check("R4 load beats count", count, 5);
        en_par = 1'b0; en_trk = 1'b0;
        load_digit(4'd9);
        check("R4 load nine", count, 9);
    endtask

    task automatic t_illegal();
        for (int v = 10; v < 16; v++) begin
            en_par = 1'b0; en_trk = 1'b0;
            load_digit(4'(v));
            check("R4 load high code", count, v);
            en_par = 1'b1; en_trk = 1'b1;
            tick();
            check("R7 high code to zero", count, 0);
        end
        en_par = 1'b0; en_trk = 1'b0;
    endtask

    task automatic t_carry();
        load_digit(4'd9);
        en_par = 1'b0; en_trk = 1'b1;
        #0.5;
        check("R6 carry trk only", carry_out, 1);
        en_par = 1'b1; en_trk = 1'b0;
        #0.5;
        check("R6 no carry without trk", carry_out, 0);
        en_par = 1'b0; en_trk = 1'b0;
        load_digit(4'd8);
        en_trk = 1'b1;
        #0.5;
        check("R6 no carry at eight", carry_out, 0);
        en_par = 1'b1;
        tick();
        check("R2 eight to nine", count, 9);
        check("R6 carry at nine", carry_out, 1);
        tick();
        check("R3 nine to zero", count, 0);
        check("R6 carry drops", carry_out, 0);
        en_par = 1'b0; en_trk = 1'b0;
    endtask

    initial begin
        t_reset();
        t_count();
        t_hold();
        t_load();
        t_illegal();
        t_carry();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule